// File: doc/BRIEF.md
# Clock-Ramping Reset Sequencer

This controller carries a processor core from a cold or warm reset to a running state. The reset pin is active low and the power-good input is active high. Once both are in their run state, the controller raises the internal clock frequency in stages. At each stage it drives a new pair of select codes to the input divider and the output divider of the clock generator. It then holds that pair for a programmed wait, which gives the generator time to lock again before the next change.

After the clock reaches full speed, the later phases of bring-up are aligned to rising edges on a forwarded-reset strobe input. Each edge passes through a synchronizer before it is used. The first edge after ramp-up starts self-test and boot-ROM loading. The next edge after self-test reports done starts initialization of the clock-forwarding link. When that initialization finishes, the controller reports that bring-up is complete.

From the complete state, a sleep request steps the dividers back down, one stage at a time, to the slowest setting. A wake request then runs the ramp-up again and returns to the complete state without repeating self-test. The divider code tables, the per-stage lock waits and the depth of the synchronizer are parameters.

Top module: `clkramp_reset_seq`

## Requirements
- R1: While `rst_n` is 0 or `pwr_ok` is 0 at a clock edge, the controller enters its idle state at that edge. In this state the divider selects carry the stage-0 codes, `bist_start` and `cfwd_start` are 0, and `init_done` is 0.
- R2: The controller leaves idle at the first clock edge that samples both `rst_n` and `pwr_ok` high. At that edge it begins ramp-up at stage 0. No other output changes until the stage-0 wait ends.
- R3: Ramp-up visits stages 0 to NSTEP-1 in ascending order. Stage k holds the codes from bits [k*DIV_W +: DIV_W] of `IN_DIV_TAB` and `OUT_DIV_TAB` for exactly the number of cycles in bits [k*CNT_W +: CNT_W] of `LOCK_TAB`.
- R4: The forwarded-reset strobe passes through SYNC_STAGES flops before its rising edge is detected. With the default of 2 stages, a rise first sampled at edge n produces a one-cycle `bist_start` pulse at edge n+2. This happens only while the controller waits after a cold ramp-up. Edges that arrive during ramp-up are ignored.
- R5: A high `bist_done` moves the controller to wait for the link strobe. The next strobe rise then produces a one-cycle `cfwd_start` pulse, with the same latency as in R4. Strobe edges that arrive while self-test is still running are ignored.
- R6: A high `cfwd_done` while the link is initializing sets `init_done` at the next edge. `init_done` stays high, with the last-stage codes on the dividers, until a sleep request or a reset.
- R7: `sleep_req` has an effect only while `init_done` is 1. At any other time it is ignored.
- R8: An accepted sleep request clears `init_done` at the next edge and selects stage NSTEP-2 at the same edge. The controller then descends to stage 0, holding each stage k for its `LOCK_TAB` count, and rests at stage 0.
- R9: `wake_req` is acted on only while the controller rests after ramp-down. It then runs the ramp-up of R3 and sets `init_done` when the last stage's wait ends, with no strobe and no new self-test. A wake request at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Reset, active low, sampled at the clock edge |
| pwr_ok | input | 1 | Power-good, active high |
| fwd_strobe | input | 1 | Forwarded-reset strobe, asynchronous to `clk` |
| bist_done | input | 1 | Self-test and boot load finished |
| cfwd_done | input | 1 | Clock-forwarding link initialization finished |
| sleep_req | input | 1 | Request to ramp down |
| wake_req | input | 1 | Request to ramp back up from sleep |
| in_div_sel | output | DIV_W | Input divider select code |
| out_div_sel | output | DIV_W | Output divider select code |
| bist_start | output | 1 | One-cycle pulse that starts self-test and boot load |
| cfwd_start | output | 1 | One-cycle pulse that starts link initialization |
| init_done | output | 1 | Bring-up complete, clock at full speed |

## Verification
Every result has a fixed latency. A start pulse follows the strobe drive by three clock edges. A stage change follows the controlling input by one edge plus the waits of the stages before it. `init_done` follows its completion input, or the end of the last stage, by one edge. The driver converts each stimulus into expected events, each stamped with a count of clock edges since time zero and computed from the bench's own copy of the tables. The monitor samples on the falling edge and reports every change of divider codes, every start pulse and every change of `init_done`. Each such change must match the head of the queue in kind, value and cycle, so a missing event, an early event or an event that should not happen is caught.

// File: rtl/clkramp_pkg.sv
package clkramp_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RAMP_UP,
      ST_WAIT_BIST,
      ST_BIST_RUN,
      ST_WAIT_CF,
      ST_CF_RUN,
      ST_DONE,
      ST_RAMP_DN,
      ST_SLEEP
   } seq_state_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic clr,
   input  logic async_in,
   output logic rise
);
   logic [SYNC_STAGES-1:0] chain;
   logic                   last_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("strobe_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clr) begin
         chain  <= '0;
         last_q <= 1'b0;
      end else begin
         chain  <= {chain[SYNC_STAGES-2:0], async_in};
         last_q <= chain[SYNC_STAGES-1];
      end
   end

   assign rise = chain[SYNC_STAGES-1] & ~last_q;

   // a rise lasts one cycle only
   assert_rise_single_R4: assert property (@(posedge clk) disable iff (clr)
      rise |=> !rise);
endmodule

// File: rtl/ramp_step_timer.sv
module ramp_step_timer #(
   parameter int                     NSTEP    = 4,
   parameter int                     CNT_W    = 8,
   parameter logic [NSTEP*CNT_W-1:0] LOCK_TAB = '1,
   localparam int                    IDX_W    = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             start_up,
   input  logic             start_dn,
   input  logic             run_up,
   input  logic             run_dn,
   output logic [IDX_W-1:0] step_idx,
   output logic             fin
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSTEP - 1);
   localparam logic [IDX_W-1:0] DN_FIRST = IDX_W'(NSTEP - 2);

   logic [CNT_W-1:0] cnt;

   function automatic logic [CNT_W-1:0] wait_of(input logic [IDX_W-1:0] idx);
      return LOCK_TAB[int'(idx)*CNT_W +: CNT_W] - CNT_W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (clr) begin
         step_idx <= '0;
         cnt      <= '0;
      end else if (start_up) begin
         step_idx <= '0;
         cnt      <= wait_of('0);
      end else if (start_dn) begin
         step_idx <= DN_FIRST;
         cnt      <= wait_of(DN_FIRST);
      end else if (run_up || run_dn) begin
         if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
         end else if (run_up && step_idx != LAST_IDX) begin
            step_idx <= step_idx + IDX_W'(1);
            cnt      <= wait_of(step_idx + IDX_W'(1));
         end else if (run_dn && step_idx != '0) begin
            step_idx <= step_idx - IDX_W'(1);
            cnt      <= wait_of(step_idx - IDX_W'(1));
         end
      end
   end

   assign fin = (cnt == '0) &&
                ((run_up && step_idx == LAST_IDX) || (run_dn && step_idx == '0));

   // a stage is held until its lock wait has run out
   assert_hold_stage_R3: assert property (@(posedge clk) disable iff (clr)
      ((run_up || run_dn) && cnt != '0 && !start_up && !start_dn) |=> $stable(step_idx));
   // ramp-up never moves to a lower stage
   assert_up_monotonic_R3: assert property (@(posedge clk) disable iff (clr)
      (run_up && !start_up && !start_dn) |=> step_idx >= $past(step_idx));
endmodule

// File: rtl/clkramp_reset_seq.sv
module clkramp_reset_seq
   import clkramp_pkg::*;
#(
   parameter int                     NSTEP       = 4,
   parameter int                     DIV_W       = 3,
   parameter int                     CNT_W       = 8,
   parameter int                     SYNC_STAGES = 2,
   parameter logic [NSTEP*DIV_W-1:0] IN_DIV_TAB  = {3'd1, 3'd3, 3'd5, 3'd7},
   parameter logic [NSTEP*DIV_W-1:0] OUT_DIV_TAB = {3'd0, 3'd2, 3'd4, 3'd6},
   parameter logic [NSTEP*CNT_W-1:0] LOCK_TAB    = {8'd16, 8'd12, 8'd8, 8'd5}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_ok,
   input  logic             fwd_strobe,
   input  logic             bist_done,
   input  logic             cfwd_done,
   input  logic             sleep_req,
   input  logic             wake_req,
   output logic [DIV_W-1:0] in_div_sel,
   output logic [DIV_W-1:0] out_div_sel,
   output logic             bist_start,
   output logic             cfwd_start,
   output logic             init_done
);
   localparam int IDX_W = (NSTEP > 1) ? $clog2(NSTEP) : 1;

   generate
      if (NSTEP < 2) begin : g_bad_nstep
         $error("clkramp_reset_seq: NSTEP must be at least 2");
      end
      if (DIV_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("clkramp_reset_seq: DIV_W and CNT_W must be positive");
      end
      for (genvar k = 0; k < NSTEP; k++) begin : g_lock_chk
         if (LOCK_TAB[k*CNT_W +: CNT_W] == '0) begin : g_zero_wait
            $error("clkramp_reset_seq: every lock wait must be at least 1");
         end
      end
   endgenerate

   seq_state_t       state;
   logic             warm;
   logic             clr;
   logic             rise;
   logic             fin;
   logic             start_up;
   logic             start_dn;
   logic [IDX_W-1:0] step_idx;

   assign clr      = !rst_n || !pwr_ok;
   assign start_up = (state == ST_IDLE) || (state == ST_SLEEP && wake_req);
   assign start_dn = (state == ST_DONE) && sleep_req;

   strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .clr      (clr),
      .async_in (fwd_strobe),
      .rise     (rise)
   );

   ramp_step_timer #(.NSTEP(NSTEP), .CNT_W(CNT_W), .LOCK_TAB(LOCK_TAB)) u_timer (
      .clk      (clk),
      .clr      (clr),
      .start_up (start_up),
      .start_dn (start_dn),
      .run_up   (state == ST_RAMP_UP),
      .run_dn   (state == ST_RAMP_DN),
      .step_idx (step_idx),
      .fin      (fin)
   );

   always_ff @(posedge clk) begin
      if (clr) begin
         state      <= ST_IDLE;
         warm       <= 1'b0;
         bist_start <= 1'b0;
         cfwd_start <= 1'b0;
      end else begin
         bist_start <= 1'b0;
         cfwd_start <= 1'b0;
         unique case (state)
            ST_IDLE:      state <= ST_RAMP_UP;
            ST_RAMP_UP:   if (fin) state <= warm ? ST_DONE : ST_WAIT_BIST;
            ST_WAIT_BIST: if (rise) begin
                             state      <= ST_BIST_RUN;
                             bist_start <= 1'b1;
                          end
            ST_BIST_RUN:  if (bist_done) state <= ST_WAIT_CF;
            ST_WAIT_CF:   if (rise) begin
                             state      <= ST_CF_RUN;
                             cfwd_start <= 1'b1;
                          end
            ST_CF_RUN:    if (cfwd_done) begin
                             state <= ST_DONE;
                             warm  <= 1'b1;
                          end
            ST_DONE:      if (sleep_req) state <= ST_RAMP_DN;
            ST_RAMP_DN:   if (fin) state <= ST_SLEEP;
            ST_SLEEP:     if (wake_req) state <= ST_RAMP_UP;
            default:      state <= ST_IDLE;
         endcase
      end
   end

   assign in_div_sel  = IN_DIV_TAB[int'(step_idx)*DIV_W +: DIV_W];
   assign out_div_sel = OUT_DIV_TAB[int'(step_idx)*DIV_W +: DIV_W];
   assign init_done   = (state == ST_DONE);

   // reset or power loss forces idle with quiet outputs at the next edge
   assert_reset_idle_R1: assert property (@(posedge clk)
      clr |=> (state == ST_IDLE && !bist_start && !cfwd_start && !init_done));
   // each start pulse lands in its own running phase
   assert_bist_phase_R4: assert property (@(posedge clk) disable iff (clr)
      bist_start |-> state == ST_BIST_RUN);
   assert_cfwd_phase_R5: assert property (@(posedge clk) disable iff (clr)
      cfwd_start |-> state == ST_CF_RUN);
   // full speed codes while complete
   assert_done_codes_R6: assert property (@(posedge clk) disable iff (clr)
      init_done |-> (in_div_sel == IN_DIV_TAB[(NSTEP-1)*DIV_W +: DIV_W] &&
                     out_div_sel == OUT_DIV_TAB[(NSTEP-1)*DIV_W +: DIV_W]));
   // ramp-down is entered only from the complete state
   assert_sleep_gate_R7: assert property (@(posedge clk) disable iff (clr)
      $rose(state == ST_RAMP_DN) |-> $past(init_done));
   // wake leaves sleep only toward ramp-up
   assert_wake_path_R9: assert property (@(posedge clk) disable iff (clr)
      ($past(state) == ST_SLEEP && state != ST_SLEEP) |-> state == ST_RAMP_UP);
endmodule

// File: tb/clkramp_reset_seq_tb.sv
`timescale 1ns/1ps
module clkramp_reset_seq_tb;
   localparam int NSTEP = 4;
   localparam int DIV_W = 3;
   localparam int CNT_W = 8;
   // bench copy of the tables (stage 0 first)
   localparam int IN_C [NSTEP]  = '{7, 5, 3, 1};
   localparam int OUT_C [NSTEP] = '{6, 4, 2, 0};
   localparam int LOCK [NSTEP]  = '{5, 8, 12, 16};

   localparam int K_DIV  = 1;
   localparam int K_BIST = 2;
   localparam int K_CF   = 3;
   localparam int K_DONE = 4;

   typedef struct packed {
      logic [7:0]  kind;
      logic [7:0]  val;
      logic [31:0] cyc;
      logic [7:0]  req;
   } ev_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_ok = 1'b0;
   logic fwd_strobe = 1'b0;
   logic bist_done = 1'b0;
   logic cfwd_done = 1'b0;
   logic sleep_req = 1'b0;
   logic wake_req = 1'b0;
   logic [DIV_W-1:0] in_div_sel, out_div_sel;
   logic bist_start, cfwd_start, init_done;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   mon_en = 1'b0;
   ev_t  exp_q[$];
   logic [7:0] p_div;
   logic       p_done;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   clkramp_reset_seq u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .fwd_strobe(fwd_strobe),
      .bist_done(bist_done), .cfwd_done(cfwd_done), .sleep_req(sleep_req),
      .wake_req(wake_req), .in_div_sel(in_div_sel), .out_div_sel(out_div_sel),
      .bist_start(bist_start), .cfwd_start(cfwd_start), .init_done(init_done)
   );

   function automatic logic [7:0] code(input int k);
      return 8'(IN_C[k] * 8 + OUT_C[k]);
   endfunction

   task automatic check(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic push(input int kind, input int val, input int at, input int req);
      ev_t e;
      e.kind = 8'(kind); e.val = 8'(val); e.cyc = 32'(at); e.req = 8'(req);
      exp_q.push_back(e);
   endtask

   // R3 ramp-up events: stage k begins start + sum of earlier waits
   task automatic push_ramp_up(input int start, output int fin_at);
      int t = start;
      for (int k = 1; k < NSTEP; k++) begin
         t += LOCK[k-1];
         push(K_DIV, code(k), t, 3);
      end
      fin_at = t + LOCK[NSTEP-1];
   endtask

   task automatic got(input int kind, input int val);
      ev_t e;
      n_chk++;
      if (exp_q.size() == 0) begin
         n_bad++;
         $display("FAIL R7/R9 unexpected event actual=kind%0d val%0d cyc%0d expected=none",
                  kind, val, cyc);
      end else begin
         e = exp_q.pop_front();
         if (int'(e.kind) != kind || int'(e.val) != val || int'(e.cyc) != cyc) begin
            n_bad++;
            $display("FAIL R%0d actual=kind%0d val%0d cyc%0d expected=kind%0d val%0d cyc%0d",
                     e.req, kind, val, cyc, e.kind, e.val, e.cyc);
         end
      end
   endtask

   // monitor: every observable change is compared with the queue head
   always @(negedge clk) begin
      if (mon_en) begin
         if ({2'b00, in_div_sel, out_div_sel} != p_div)
            got(K_DIV, int'({2'b00, in_div_sel, out_div_sel}));
         if (bist_start) got(K_BIST, 1);
         if (cfwd_start) got(K_CF, 1);
         if (init_done != p_done) got(K_DONE, int'(init_done));
      end
      p_div  = {2'b00, in_div_sel, out_div_sel};
      p_done = init_done;
   end

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic pulse_strobe();
      fwd_strobe = 1'b1;
      repeat (2) @(negedge clk);
      fwd_strobe = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      int c, t_end;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 in_div", int'(in_div_sel), IN_C[0]);
      check("R1 out_div", int'(out_div_sel), OUT_C[0]);
      check("R1 bist_start", int'(bist_start), 0);
      check("R1 cfwd_start", int'(cfwd_start), 0);
      check("R1 init_done", int'(init_done), 0);
      mon_en = 1'b1;

      // R2: reset released but power not good: nothing moves
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check("R2 held at stage 0", int'({in_div_sel, out_div_sel}), int'(code(0)));

      // R2 R3 cold ramp-up
      c = cyc;
      pwr_ok = 1'b1;
      push_ramp_up(c + 1, t_end);
      wait_until(c + 10);
      pulse_strobe();                       // R4 ignored during ramp
      wait_until(t_end + 2);

      // R4 self-test start, three edges after the strobe is driven
      c = cyc;
      push(K_BIST, 1, c + 3, 4);
      pulse_strobe();
      repeat (4) @(negedge clk);
      pulse_strobe();                       // R5 ignored while self-test runs
      repeat (4) @(negedge clk);
      sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;   // R7 ignored
      bist_done = 1'b1; @(negedge clk); bist_done = 1'b0;
      @(negedge clk);

      // R5 link start
      c = cyc;
      push(K_CF, 1, c + 3, 5);
      pulse_strobe();
      repeat (4) @(negedge clk);
      wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;     // R9 ignored

      // R6 completion
      c = cyc;
      push(K_DONE, 1, c + 1, 6);
      cfwd_done = 1'b1; @(negedge clk); cfwd_done = 1'b0;
      repeat (3) @(negedge clk);
      wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;     // R9 ignored in done
      repeat (2) @(negedge clk);
      check("R6 init_done held", int'(init_done), 1);
      check("R6 full speed codes", int'({in_div_sel, out_div_sel}), int'(code(NSTEP-1)));

      // R8 ramp-down
      c = cyc;
      push(K_DIV, code(NSTEP-2), c + 1, 8);
      push(K_DONE, 0, c + 1, 8);
      t_end = c + 1;
      for (int k = NSTEP - 2; k > 0; k--) begin
         t_end += LOCK[k];
         push(K_DIV, code(k-1), t_end, 8);
      end
      sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
      wait_until(t_end + LOCK[0] + 4);
      check("R8 rest at stage 0", int'({in_div_sel, out_div_sel}), int'(code(0)));

      // R9 wake: ramp-up then done, no strobe needed
      c = cyc;
      push_ramp_up(c + 1, t_end);
      push(K_DONE, 1, t_end, 9);
      wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
      wait_until(t_end + 3);
      check("R9 init_done after wake", int'(init_done), 1);

      // R1 power loss mid-run
      c = cyc;
      push(K_DIV, code(0), c + 1, 1);
      push(K_DONE, 0, c + 1, 1);
      pwr_ok = 1'b0;
      repeat (3) @(negedge clk);

      // R2 cold restart, waits for a strobe again
      c = cyc;
      pwr_ok = 1'b1;
      push_ramp_up(c + 1, t_end);
      wait_until(t_end + 5);
      check("R2 restart waits for strobe", int'(init_done), 0);
      check("R3 all expected events seen", exp_q.size(), 0);
      summary();
      $finish;
   end
endmodule